// File: doc/BRIEF.md
# ADC power mode sequencer

This block sequences the power states of a serially accessed converter. It follows a 16-clock serial frame framed by an active-low chip select. It picks a write flag, a register-select field and a two-bit power-mode field out of the serial data. From these it drives three enables: the analog core supply, the reference supply and the track/hold switch. It also flags, once per completed frame, whether that frame produced a usable conversion.

There are four power modes. Each has its own point of entry and its own wake trigger. Normal keeps everything on. Full shutdown turns everything off and stays there until the mode field is rewritten. Auto shutdown and auto standby drop power after each valid conversion and wake on the next chip-select falling edge. Standby keeps the reference alive and wakes within one dummy frame. The shutdown wake-ups last a programmable number of system clocks.

All serial inputs are treated as synchronous to the system clock. Edges are found by comparing each input with its value one clock earlier.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset the mode is normal (pm_mode = 00). core_en, ref_en, track and ready are all 1 and result_valid is 0.
- R2: A frame opens on a chip-select falling edge and completes on the 16th serial-clock rising edge while chip select stays low. Bits arrive MSB first. During a valid frame in the powered state, track is 0 (hold).
- R3: The mode register takes frame bits [9:8] only when bit 15 (write) is 1 and bits [14:12] equal 3'b010 (control select). Any other frame leaves pm_mode unchanged. The mode field encodes 00 normal, 11 full shutdown, 10 auto shutdown and 01 auto standby.
- R4: If chip select rises before the 16th serial clock, the frame is dropped. There is no mode write, no power-state change and no result_valid pulse.
- R5: In normal mode the block stays fully powered between frames. Every frame started while ready pulses result_valid once, in the cycle after the frame completes.
- R6: Completing a frame whose final mode is 11 turns core_en, ref_en, track and ready off. They stay off through further frames that leave the mode at 11.
- R7: While in full shutdown, a frame writing mode 00 leaves power off until chip select rises. On that rising edge core_en and ref_en turn on, track goes to 1 and ready stays 0. ready rises exactly WAKE_FULL_CYC clocks after the edge that sampled the rise.
- R8: In auto shutdown, a valid frame ends with core_en, ref_en, track and ready all 0. The next chip-select falling edge turns core_en, ref_en and track on at once. ready follows WAKE_AUTO_CYC clocks later.
- R9: In auto standby, a valid frame ends with core_en 0, track 0 and ref_en kept at 1. The next falling edge powers the core with track at 1. That frame is a dummy: it gives no valid result, and the block stays powered after it. The following frame is valid and drops back to standby.
- R10: A frame that selects an automatic low-power mode while the block is powered completes at full power with a valid result. The new state applies only from the end of that frame.
- R11: A frame that starts while ready is 0 never pulses result_valid.
- R12: pm_mode keeps its value through every low-power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame chip select, active low |
| sclk | input | 1 | Serial clock, data sampled on its rising edge |
| sdin | input | 1 | Serial data in, MSB first |
| core_en | output | 1 | Analog core power enable |
| ref_en | output | 1 | Reference power enable |
| track | output | 1 | 1 = track/hold tracking, 0 = holding |
| ready | output | 1 | Fully powered and settled |
| result_valid | output | 1 | One-clock pulse: the frame just completed gave a valid result |
| pm_mode | output | 2 | Current power-mode field |

## Verification
The frames sent cover four cases: non-write frames, writes to a non-control select, truncated frames and true control writes. Together they separate field decoding from frame completion. Each of the four modes is entered from a powered state and left again. The standby and shutdown wake paths receive back-to-back frames, so the dummy or early frame and the following valid frame are told apart by their result_valid pulses. The ready edges after both wake-ups are sampled one clock before and at the expected cycle, which separates an off-by-one delay from a correct one. A behavioural reference model follows every clock, so transient values of track and the power enables are compared along with the settled states.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [2:0] {
    PS_ON   = 3'd0,
    PS_WAKE = 3'd1,
    PS_FULL = 3'd2,
    PS_SHUT = 3'd3,
    PS_STBY = 3'd4
  } pwr_state_t;

  localparam logic [1:0] PM_NORMAL = 2'b00;
  localparam logic [1:0] PM_FULL   = 2'b11;
  localparam logic [1:0] PM_ASHUT  = 2'b10;
  localparam logic [1:0] PM_ASTBY  = 2'b01;

  // State reached when a frame completes, given the mode that results from it.
  // A frame that was not valid (dummy or early) never sends the block back
  // into an automatic low-power state.
  function automatic pwr_state_t frame_end_state(pwr_state_t cur, logic [1:0] nm,
                                                 logic was_ok, pwr_state_t dflt);
    pwr_state_t r;
    r = dflt;
    case (cur)
      PS_FULL: begin
        if (nm == PM_ASHUT)      r = PS_SHUT;
        else if (nm == PM_ASTBY) r = PS_STBY;
      end
      PS_ON, PS_WAKE: begin
        if (nm == PM_FULL)                  r = PS_FULL;
        else if (nm == PM_ASHUT && was_ok)  r = PS_SHUT;
        else if (nm == PM_ASTBY && was_ok)  r = PS_STBY;
      end
      default: r = dflt;
    endcase
    return r;
  endfunction

  // Mode after a completed frame.
  function automatic logic [1:0] frame_mode(logic hit, logic [1:0] field, logic [1:0] cur);
    return hit ? field : cur;
  endfunction

endpackage

// File: rtl/adc_frame_rx.sv
module adc_frame_rx #(
  parameter int FRAME_BITS = 16,
  parameter int WR_POS     = 15,
  parameter int SEL_LSB    = 12,
  parameter int SEL_W      = 3,
  parameter int PM_LSB     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdin,
  output logic             frame_start,
  output logic             frame_rise,
  output logic             frame_done,
  output logic             frame_abort,
  output logic             frame_active,
  output logic             wr_bit,
  output logic [SEL_W-1:0] sel_bits,
  output logic [1:0]       pm_bits
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  // serial slot (0 = first bit shifted) holding frame bit position pos
  function automatic int slot(int pos);
    return FRAME_BITS - 1 - pos;
  endfunction

  logic             cs_q, sclk_q, active;
  logic [CNT_W-1:0] cnt;
  logic             sclk_rise, shift_en, last_bit;

  assign frame_start  = cs_q & ~cs_n;
  assign frame_rise   = ~cs_q & cs_n;
  assign sclk_rise    = ~sclk_q & sclk;
  assign shift_en     = active & sclk_rise & ~frame_rise;
  assign last_bit     = (cnt == CNT_W'(FRAME_BITS - 1));
  assign frame_done   = shift_en & last_bit;
  assign frame_abort  = active & frame_rise;
  assign frame_active = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (frame_start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (frame_abort) begin
        active <= 1'b0;
      end else if (shift_en) begin
        if (last_bit) active <= 1'b0;
        else          cnt    <= cnt + 1'b1;
      end
    end
  end

  logic wr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       wr_q <= 1'b0;
    else if (shift_en && cnt == CNT_W'(slot(WR_POS))) wr_q <= sdin;
  end
  assign wr_bit = wr_q;

  for (genvar i = 0; i < SEL_W; i++) begin : g_sel
    logic b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                              b_q <= 1'b0;
      else if (shift_en && cnt == CNT_W'(slot(SEL_LSB + i)))   b_q <= sdin;
    end
    assign sel_bits[i] = b_q;
  end

  for (genvar i = 0; i < 2; i++) begin : g_pm
    logic b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                             b_q <= 1'b0;
      else if (shift_en && cnt == CNT_W'(slot(PM_LSB + i)))   b_q <= sdin;
    end
    assign pm_bits[i] = b_q;
  end

  // a new frame can only open once the previous one is over
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !active);

endmodule

// File: rtl/adc_wake_timer.sv
module adc_wake_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CW'(1));

  p_expire_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !expire);

endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int SEL_W         = 3,
  parameter int CTRL_SEL      = 2,
  parameter int WAKE_FULL_CYC = 40,
  parameter int WAKE_AUTO_CYC = 12,
  parameter int TW            = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_rise,
  input  logic             frame_done,
  input  logic             frame_abort,
  input  logic             frame_active,
  input  logic             wr_bit,
  input  logic [SEL_W-1:0] sel_bits,
  input  logic [1:0]       pm_bits,
  input  logic             expire,
  output logic             timer_start,
  output logic [TW-1:0]    timer_len,
  output logic             core_en,
  output logic             ref_en,
  output logic             track,
  output logic             ready,
  output logic             result_valid,
  output logic [1:0]       pm_mode
);
  pwr_state_t state, state_n;
  logic [1:0] mode, nm;
  logic       frame_ok, wake_pend, valid_q, sel_hit;

  assign sel_hit = wr_bit && (sel_bits == SEL_W'(CTRL_SEL));
  assign nm      = frame_mode(sel_hit, pm_bits, mode);

  always_comb begin
    state_n     = state;
    timer_start = 1'b0;
    timer_len   = '0;
    if (state == PS_WAKE && expire) state_n = PS_ON;
    if (frame_start) begin
      if (state == PS_SHUT) begin
        state_n     = PS_WAKE;
        timer_start = 1'b1;
        timer_len   = TW'(WAKE_AUTO_CYC);
      end else if (state == PS_STBY) begin
        state_n = PS_ON;
      end
    end
    if (frame_rise && wake_pend) begin
      state_n     = PS_WAKE;
      timer_start = 1'b1;
      timer_len   = TW'(WAKE_FULL_CYC);
    end
    if (frame_done) state_n = frame_end_state(state, nm, frame_ok, state_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_ON;
      mode      <= PM_NORMAL;
      frame_ok  <= 1'b0;
      wake_pend <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      state   <= state_n;
      valid_q <= frame_done && frame_ok;
      if (frame_done) mode <= nm;
      if (frame_start) frame_ok <= (state == PS_ON);
      if (frame_done && state == PS_FULL && nm == PM_NORMAL) wake_pend <= 1'b1;
      else if (frame_rise)                                   wake_pend <= 1'b0;
    end
  end

  assign core_en      = (state == PS_ON) || (state == PS_WAKE);
  assign ref_en       = core_en || (state == PS_STBY);
  assign ready        = (state == PS_ON);
  assign track        = (state == PS_WAKE) || ((state == PS_ON) && (!frame_active || !frame_ok));
  assign result_valid = valid_q;
  assign pm_mode      = mode;

  p_core_needs_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> ref_en);
  p_off_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> !track);
  p_valid_after_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(ready));
  p_mode_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(pm_mode));
  p_abort_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_abort && state != PS_WAKE) |=> $stable(state));
  p_wake_on_cs_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) |-> $past(frame_start || frame_rise));

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int FRAME_BITS    = 16,
  parameter int WR_POS        = 15,
  parameter int SEL_LSB       = 12,
  parameter int SEL_W         = 3,
  parameter int PM_LSB        = 8,
  parameter int CTRL_SEL      = 2,
  parameter int WAKE_FULL_CYC = 40,
  parameter int WAKE_AUTO_CYC = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdin,
  output logic       core_en,
  output logic       ref_en,
  output logic       track,
  output logic       ready,
  output logic       result_valid,
  output logic [1:0] pm_mode
);
  localparam int WAKE_MAX = (WAKE_FULL_CYC > WAKE_AUTO_CYC) ? WAKE_FULL_CYC : WAKE_AUTO_CYC;
  localparam int TW       = $clog2(WAKE_MAX + 1);

  logic             frame_start, frame_rise, frame_done, frame_abort, frame_active;
  logic             wr_bit, timer_start, expire;
  logic [SEL_W-1:0] sel_bits;
  logic [1:0]       pm_bits;
  logic [TW-1:0]    timer_len;

  adc_frame_rx #(
    .FRAME_BITS(FRAME_BITS), .WR_POS(WR_POS), .SEL_LSB(SEL_LSB),
    .SEL_W(SEL_W), .PM_LSB(PM_LSB)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .frame_start(frame_start), .frame_rise(frame_rise), .frame_done(frame_done),
    .frame_abort(frame_abort), .frame_active(frame_active),
    .wr_bit(wr_bit), .sel_bits(sel_bits), .pm_bits(pm_bits)
  );

  adc_wake_timer #(.CW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(timer_start), .len(timer_len), .expire(expire)
  );

  adc_pwr_fsm #(
    .SEL_W(SEL_W), .CTRL_SEL(CTRL_SEL), .WAKE_FULL_CYC(WAKE_FULL_CYC),
    .WAKE_AUTO_CYC(WAKE_AUTO_CYC), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_rise(frame_rise), .frame_done(frame_done),
    .frame_abort(frame_abort), .frame_active(frame_active),
    .wr_bit(wr_bit), .sel_bits(sel_bits), .pm_bits(pm_bits), .expire(expire),
    .timer_start(timer_start), .timer_len(timer_len),
    .core_en(core_en), .ref_en(ref_en), .track(track), .ready(ready),
    .result_valid(result_valid), .pm_mode(pm_mode)
  );

endmodule

// File: tb/adc_pwr_seq_tb.sv
`timescale 1ns/1ps
module adc_pwr_seq_tb;
  localparam int WF = 40;
  localparam int WA = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic core_en, ref_en, track, ready, result_valid;
  logic [1:0] pm_mode;

  always #2 clk = ~clk;

  adc_pwr_seq #(.WAKE_FULL_CYC(WF), .WAKE_AUTO_CYC(WA)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .core_en(core_en), .ref_en(ref_en), .track(track), .ready(ready),
    .result_valid(result_valid), .pm_mode(pm_mode)
  );

  int n_chk = 0, n_fail = 0, vcnt = 0;
  bit finished = 0, cmp_en = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // states: 0 on, 1 waking, 2 full off, 3 auto off, 4 standby
  int ms = 0, mmode = 0, mcnt = 0, mwk = 0;
  bit mact = 0, mok = 0, mpend = 0, mvalid = 0, mpcs = 1, mpsc = 0;
  logic [15:0] mword = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mmode = 0; mcnt = 0; mwk = 0; mact = 0; mok = 0; mpend = 0;
      mvalid = 0; mpcs = 1; mpsc = 0; mword = 0;
    end else begin
      bit csf, csr, scr, done, hit;
      int nms, nm;
      csf = mpcs && !cs_n;
      csr = !mpcs && cs_n;
      scr = !mpsc && sclk;
      done = 0; nms = ms; mvalid = 0;
      if (ms == 1 && mwk == 1) nms = 0;
      if (mwk > 0) mwk--;
      if (csf) begin
        if (ms == 3) begin nms = 1; mwk = WA; end
        else if (ms == 4) nms = 0;
        mok = (ms == 0); mact = 1; mcnt = 0;
      end else if (csr) begin
        mact = 0;
        if (mpend) begin mpend = 0; nms = 1; mwk = WF; end
      end else if (scr && mact) begin
        mword = {mword[14:0], sdin};
        mcnt++;
        if (mcnt == 16) begin done = 1; mact = 0; end
      end
      if (done) begin
        hit = mword[15] && (mword[14:12] == 3'd2);
        nm = hit ? int'(mword[9:8]) : mmode;
        mvalid = mok;
        if (ms == 2) begin
          if (nm == 0) mpend = 1;
          else if (nm == 2) nms = 3;
          else if (nm == 1) nms = 4;
        end else if (ms == 0 || ms == 1) begin
          if (nm == 3) nms = 2;
          else if (nm == 2 && mok) nms = 3;
          else if (nm == 1 && mok) nms = 4;
        end
        mmode = nm;
      end
      ms = nms; mpcs = cs_n; mpsc = sclk;
    end
  end

  always @(negedge clk) begin
    if (result_valid) vcnt++;
    if (cmp_en && rst_n) begin
      int m_core, m_ref, m_trk, m_rdy;
      m_core = (ms == 0 || ms == 1) ? 1 : 0;
      m_ref  = (m_core == 1 || ms == 4) ? 1 : 0;
      m_rdy  = (ms == 0) ? 1 : 0;
      m_trk  = (ms == 1 || (ms == 0 && (!mact || !mok))) ? 1 : 0;
      chk_eq("R6 core_en model", int'(core_en), m_core);
      chk_eq("R9 ref_en model", int'(ref_en), m_ref);
      chk_eq("R2 track model", int'(track), m_trk);
      chk_eq("R7 ready model", int'(ready), m_rdy);
      chk_eq("R11 result_valid model", int'(result_valid), int'(mvalid));
      chk_eq("R12 pm_mode model", int'(pm_mode), mmode);
    end
  end

  // ---------------- stimulus helpers ----------------
  int mid_core = 0, mid_track = 0, pre_core = 0, fv = 0, v0 = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input bit wr, input logic [2:0] sel, input logic [1:0] pm);
    return {wr, sel, 2'b01, pm, 8'h5A};
  endfunction

  task automatic start_frame();
    v0 = vcnt;
    cs_n = 1'b0;
    tick(1);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdin = w[15-i];
      sclk = 1'b0;
      tick(1);
      sclk = 1'b1;
      tick(1);
      if (i == 7) begin mid_core = int'(core_en); mid_track = int'(track); end
    end
    sclk = 1'b0;
    tick(1);
    pre_core = int'(core_en);
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    tick(2);
    fv = vcnt - v0;
  endtask

  task automatic frame(input logic [15:0] w, input int nbits);
    start_frame();
    shift_bits(w, nbits);
    end_frame();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    wrap_up();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    cmp_en = 1;
    // R1 reset state
    chk_eq("R1 core_en", int'(core_en), 1);
    chk_eq("R1 ref_en", int'(ref_en), 1);
    chk_eq("R1 track", int'(track), 1);
    chk_eq("R1 ready", int'(ready), 1);
    chk_eq("R1 pm_mode", int'(pm_mode), 0);

    // non-write frame carrying 11 in the mode field
    frame(mk(0, 3'd2, 2'b11), 16);
    chk_eq("R2 hold mid-frame", mid_track, 0);
    chk_eq("R5 valid pulse", fv, 1);
    chk_eq("R3 no write without flag", int'(pm_mode), 0);
    chk_eq("R5 stays on", int'(core_en), 1);

    // write to a different select
    frame(mk(1, 3'd3, 2'b11), 16);
    chk_eq("R3 other select ignored", int'(pm_mode), 0);
    chk_eq("R5 valid pulse again", fv, 1);

    // truncated control write
    frame(mk(1, 3'd2, 2'b11), 10);
    chk_eq("R4 abort no write", int'(pm_mode), 0);
    chk_eq("R4 abort still on", int'(core_en), 1);
    chk_eq("R4 abort no valid", fv, 0);

    // full shutdown
    frame(mk(1, 3'd2, 2'b11), 16);
    chk_eq("R6 write frame valid", fv, 1);
    chk_eq("R6 core off", int'(core_en), 0);
    chk_eq("R6 ref off", int'(ref_en), 0);
    chk_eq("R6 hold", int'(track), 0);
    chk_eq("R6 not ready", int'(ready), 0);
    chk_eq("R3 mode 11", int'(pm_mode), 3);
    frame(mk(0, 3'd0, 2'b00), 16);
    chk_eq("R6 off mid-frame", mid_core, 0);
    chk_eq("R6 stays off", int'(core_en), 0);
    chk_eq("R11 no valid while off", fv, 0);

    // wake from full shutdown
    start_frame();
    shift_bits(mk(1, 3'd2, 2'b00), 16);
    chk_eq("R7 off until cs rises", pre_core, 0);
    end_frame();
    chk_eq("R7 core on after rise", int'(core_en), 1);
    chk_eq("R7 track during wake", int'(track), 1);
    chk_eq("R7 not ready yet", int'(ready), 0);
    chk_eq("R11 wake frame invalid", fv, 0);
    tick(WF - 2);
    chk_eq("R7 ready one early", int'(ready), 0);
    tick(1);
    chk_eq("R7 ready on time", int'(ready), 1);
    chk_eq("R12 mode 00", int'(pm_mode), 0);

    // auto standby
    frame(mk(1, 3'd2, 2'b01), 16);
    chk_eq("R10 powered through frame", mid_core, 1);
    chk_eq("R10 setting frame valid", fv, 1);
    chk_eq("R9 core off", int'(core_en), 0);
    chk_eq("R9 ref kept", int'(ref_en), 1);
    chk_eq("R9 hold", int'(track), 0);
    frame(mk(0, 3'd0, 2'b00), 16);
    chk_eq("R9 dummy powered", mid_core, 1);
    chk_eq("R9 dummy tracks", mid_track, 1);
    chk_eq("R9 dummy invalid", fv, 0);
    chk_eq("R9 on after dummy", int'(ready), 1);
    frame(mk(0, 3'd0, 2'b00), 16);
    chk_eq("R9 second valid", fv, 1);
    chk_eq("R9 back to standby", int'(core_en), 0);
    chk_eq("R12 mode kept standby", int'(pm_mode), 1);

    // auto shutdown
    frame(mk(1, 3'd2, 2'b10), 16);
    chk_eq("R9 dummy write invalid", fv, 0);
    chk_eq("R3 mode 10", int'(pm_mode), 2);
    chk_eq("R9 powered after dummy", int'(core_en), 1);
    frame(mk(0, 3'd0, 2'b00), 16);
    chk_eq("R8 valid frame", fv, 1);
    chk_eq("R8 core off", int'(core_en), 0);
    chk_eq("R8 ref off", int'(ref_en), 0);
    chk_eq("R8 hold", int'(track), 0);
    chk_eq("R12 mode kept shutdown", int'(pm_mode), 2);
    start_frame();
    chk_eq("R8 core on at fall", int'(core_en), 1);
    chk_eq("R8 ref on at fall", int'(ref_en), 1);
    chk_eq("R8 track at fall", int'(track), 1);
    chk_eq("R8 not ready at fall", int'(ready), 0);
    tick(WA - 1);
    chk_eq("R8 ready one early", int'(ready), 0);
    tick(1);
    chk_eq("R8 ready on time", int'(ready), 1);
    shift_bits(mk(0, 3'd0, 2'b00), 16);
    end_frame();
    chk_eq("R11 early frame invalid", fv, 0);
    chk_eq("R8 on after wake frame", int'(core_en), 1);
    frame(mk(0, 3'd0, 2'b00), 16);
    chk_eq("R8 valid then off", fv, 1);
    chk_eq("R8 off again", int'(core_en), 0);

    // back to normal from auto shutdown
    frame(mk(1, 3'd2, 2'b00), 16);
    chk_eq("R3 mode 00", int'(pm_mode), 0);
    chk_eq("R11 wake write invalid", fv, 0);
    tick(WA);
    frame(mk(0, 3'd0, 2'b00), 16);
    chk_eq("R5 valid", fv, 1);
    chk_eq("R5 on", int'(ready), 1);
    frame(mk(0, 3'd5, 2'b10), 16);
    chk_eq("R5 valid back-to-back", fv, 1);
    chk_eq("R5 still on", int'(core_en), 1);

    tick(4);
    wrap_up();
  end

endmodule